// File: doc/BRIEF.md
# Multi-Output PWM Generator with Atomic Timing Update

This block drives six phase-related PWM outputs from one switching-period counter. Four outputs drive the primary-side switches and two drive the synchronous rectifiers. Each output has its own programmable turn-on and turn-off position within the period. A duty command from the control loop can move the turn-off edge of any output chosen by a mask. A seventh, auxiliary output runs from its own period counter. It can therefore run at another frequency, for example to clock a pre-regulator stage or to serve as a reference clock.

All timing values (the periods, the edges and the duty-shift mask) are first written into holding registers, and the waveform does not change. Writing the commit bit arms a transfer. At the next rollover of the main period, every holding register moves into the active set in the same cycle. All seven outputs are then held low for one whole switching period, so that no output can glitch while the timing relation between outputs changes. The per-output enable mask is not held back and acts at once.

Top module: `pwm_multi_out`

## Requirements
- R1: After a synchronous reset, all seven outputs and `commit_pending` are low. The active main and auxiliary periods are 16, all edges and the shift mask are 0, all enables are 0 and the latched duty is 0.
- R2: The main counter counts 0 to P-1 and then wraps, where P is the active main period. Output i is high in the cycle after the counter holds a value c with rise_i <= c < fall_i, where the edges are the effective (clamped) values.
- R3: Every output has its own rise and fall register: main output i uses rise at address 1+i and fall at address 7+i, and the auxiliary output uses addresses 15 and 16. A change to one output does not move any other output.
- R4: Writes to the holding registers do not change any output until a commit. The holding registers are main period (0), rise/fall (see R3), shift mask (13, bit i = main output i), aux period (14). A commit is a write to address 18 with data bit 0 = 1; a write there with bit 0 = 0 does nothing.
- R5: The transfer happens at the first main rollover that follows the commit write, and the pending flag clears at that rollover. A commit written on the rollover edge itself waits for the following rollover.
- R6: After a transfer, all seven outputs are low for exactly one full new main period. They then follow the new timing.
- R7: Address 17 holds the enable mask: bit i enables main output i and bit 6 enables the auxiliary output. The mask takes effect immediately, and a disabled output stays low.
- R8: `duty_cmd` is sampled only on the main rollover. For main outputs whose shift-mask bit is set, the sampled value is added to the fall edge for the whole next period.
- R9: Any edge at or beyond the period is clamped to the period. If the effective rise is not below the effective fall, the output stays low for that period, so an output never toggles twice per period.
- R10: The auxiliary output compares its own counter, which wraps at the active aux period, against its own edges. Its counter restarts at 0 on a transfer.
- R11: `commit_pending` is high from the cycle after a commit write until the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | CW (8) | Register write data |
| duty_cmd | input | CW (8) | Duty shift from the control loop |
| drv_out | output | 6 | Main outputs: bits 0-3 primary, bits 4-5 rectifier |
| aux_out | output | 1 | Auxiliary PWM output |
| commit_pending | output | 1 | Transfer armed and not yet done |

## Verification
The critical collision is a commit write (or a holding-register write) landing on the same clock edge as a main-period rollover. In that case the rollover must transfer the old holding values and leave the new commit armed for one more period. The bench provokes this in a directed way: it waits until the reference model's counter sits at P-1 and then issues the commit. Random traffic also produces many such coincidences. Each cycle, the outputs and the pending flag are compared against a cycle-accurate reference model built from the requirements.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int NMAIN = 6;
  localparam int NCH   = NMAIN + 1;
  localparam int AW    = 5;

  localparam int A_PERIOD = 0;
  localparam int A_RISE0  = 1;
  localparam int A_FALL0  = 7;
  localparam int A_ADJ    = 13;
  localparam int A_APER   = 14;
  localparam int A_ARISE  = 15;
  localparam int A_AFALL  = 16;
  localparam int A_ENABLE = 17;
  localparam int A_COMMIT = 18;

  function automatic int rise_addr(input int ch);
    return (ch < NMAIN) ? A_RISE0 + ch : A_ARISE;
  endfunction

  function automatic int fall_addr(input int ch);
    return (ch < NMAIN) ? A_FALL0 + ch : A_AFALL;
  endfunction
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  logic [CW:0] nxt;

  assign nxt  = {1'b0, cnt} + (CW+1)'(1);
  assign wrap = (nxt >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (restart || wrap) cnt <= '0;
    else                   cnt <= nxt[CW-1:0];
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) || (cnt < period));
endmodule

// File: rtl/pwm_timing_bank.sv
module pwm_timing_bank
  import pwm_pkg::*;
#(
  parameter int CW         = 8,
  parameter int DEF_PERIOD = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [CW-1:0]            wr_data,
  input  logic [CW-1:0]            duty_cmd,
  input  logic                     roll,
  output logic [CW-1:0]            act_per,
  output logic [CW-1:0]            act_aper,
  output logic [NCH-1:0][CW-1:0]   act_rise,
  output logic [NCH-1:0][CW-1:0]   act_fall,
  output logic [NMAIN-1:0]         act_adj,
  output logic [NCH-1:0]           en,
  output logic [CW-1:0]            duty_q,
  output logic                     pend,
  output logic                     blank,
  output logic                     load
);
  logic [CW-1:0]    sh_per, sh_aper;
  logic [NMAIN-1:0] sh_adj;
  logic             wr_commit;

  function automatic logic hit(input logic [AW-1:0] a, input int target);
    return a == AW'(target);
  endfunction

  assign wr_commit = wr_en && hit(wr_addr, A_COMMIT) && wr_data[0];
  assign load      = roll && pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_per  <= CW'(DEF_PERIOD);
      sh_aper <= CW'(DEF_PERIOD);
      sh_adj  <= '0;
      en      <= '0;
    end else if (wr_en) begin
      if (hit(wr_addr, A_PERIOD)) sh_per  <= wr_data;
      if (hit(wr_addr, A_APER))   sh_aper <= wr_data;
      if (hit(wr_addr, A_ADJ))    sh_adj  <= wr_data[NMAIN-1:0];
      if (hit(wr_addr, A_ENABLE)) en      <= wr_data[NCH-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_per  <= CW'(DEF_PERIOD);
      act_aper <= CW'(DEF_PERIOD);
      act_adj  <= '0;
    end else if (load) begin
      act_per  <= sh_per;
      act_aper <= sh_aper;
      act_adj  <= sh_adj;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_edge
    localparam int RA = rise_addr(i);
    localparam int FA = fall_addr(i);
    logic [CW-1:0] sh_r, sh_f, ac_r, ac_f;

    always_ff @(posedge clk) begin
      if (rst) begin
        sh_r <= '0;
        sh_f <= '0;
      end else if (wr_en) begin
        if (hit(wr_addr, RA)) sh_r <= wr_data;
        if (hit(wr_addr, FA)) sh_f <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ac_r <= '0;
        ac_f <= '0;
      end else if (load) begin
        ac_r <= sh_r;
        ac_f <= sh_f;
      end
    end

    assign act_rise[i] = ac_r;
    assign act_fall[i] = ac_f;
  end

  always_ff @(posedge clk) begin
    if (rst)            pend <= 1'b0;
    else if (wr_commit) pend <= 1'b1;
    else if (load)      pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blank  <= 1'b0;
      duty_q <= '0;
    end else if (roll) begin
      blank  <= load;
      duty_q <= duty_cmd;
    end
  end

  // R8
  duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(roll) |-> $stable(duty_q));

  // R4
  pend_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(wr_en && wr_addr == AW'(A_COMMIT) && wr_data[0]));
endmodule

// File: rtl/pwm_edge_cell.sv
module pwm_edge_cell #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] rise,
  input  logic [CW-1:0] fall,
  input  logic [CW-1:0] shift,
  input  logic          enable,
  input  logic          blank,
  output logic          out
);
  logic [CW:0]   fsum;
  logic [CW-1:0] rise_c, fall_c;
  logic          win;

  assign fsum   = {1'b0, fall} + {1'b0, shift};
  assign rise_c = (rise > period) ? period : rise;
  assign fall_c = (fsum > {1'b0, period}) ? period : fsum[CW-1:0];
  assign win    = (cnt >= rise_c) && (cnt < fall_c);

  always_ff @(posedge clk) begin
    if (rst) out <= 1'b0;
    else     out <= enable && !blank && win;
  end

  // R7
  disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !out);
endmodule

// File: rtl/pwm_multi_out.sv
module pwm_multi_out
  import pwm_pkg::*;
#(
  parameter int CW         = 8,
  parameter int DEF_PERIOD = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic [CW-1:0]     duty_cmd,
  output logic [NMAIN-1:0]  drv_out,
  output logic              aux_out,
  output logic              commit_pending
);
  logic [CW-1:0]           act_per, act_aper, duty_q;
  logic [NCH-1:0][CW-1:0]  act_rise, act_fall;
  logic [NMAIN-1:0]        act_adj;
  logic [NCH-1:0]          en;
  logic                    pend, blank, load;
  logic [CW-1:0]           mcnt, acnt;
  logic                    mwrap, awrap;
  logic [NCH-1:0]          cell_out;

  pwm_timing_bank #(.CW(CW), .DEF_PERIOD(DEF_PERIOD)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .duty_cmd(duty_cmd), .roll(mwrap), .act_per(act_per), .act_aper(act_aper),
    .act_rise(act_rise), .act_fall(act_fall), .act_adj(act_adj), .en(en),
    .duty_q(duty_q), .pend(pend), .blank(blank), .load(load)
  );

  pwm_counter #(.CW(CW)) u_main_ctr (
    .clk(clk), .rst(rst), .restart(1'b0), .period(act_per),
    .cnt(mcnt), .wrap(mwrap)
  );

  pwm_counter #(.CW(CW)) u_aux_ctr (
    .clk(clk), .rst(rst), .restart(load), .period(act_aper),
    .cnt(acnt), .wrap(awrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_cell
    logic [CW-1:0] c_cnt, c_per, c_shift;
    if (i < NMAIN) begin : g_main
      assign c_cnt   = mcnt;
      assign c_per   = act_per;
      assign c_shift = act_adj[i] ? duty_q : '0;
    end else begin : g_aux
      assign c_cnt   = acnt;
      assign c_per   = act_aper;
      assign c_shift = '0;
    end
    pwm_edge_cell #(.CW(CW)) u_cell (
      .clk(clk), .rst(rst), .cnt(c_cnt), .period(c_per),
      .rise(act_rise[i]), .fall(act_fall[i]), .shift(c_shift),
      .enable(en[i]), .blank(blank), .out(cell_out[i])
    );
  end

  assign drv_out        = cell_out[NMAIN-1:0];
  assign aux_out        = cell_out[NMAIN];
  assign commit_pending = pend;

  // R6
  blank_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    blank |=> (drv_out == '0) && !aux_out);

  // R5
  commit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && mwrap && !(wr_en && wr_addr == AW'(A_COMMIT) && wr_data[0])) |=> !pend);

  // R10
  aux_restart_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (acnt == '0));

  // R2
  aux_wrap_seen_chk: assert property (@(posedge clk) disable iff (rst)
    (awrap && !load) |=> (acnt == '0));
endmodule

// File: tb/tb_pwm_multi_out.sv
`timescale 1ns/1ps
module tb_pwm_multi_out;
  localparam int CW = 8;
  localparam int NM = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [4:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] duty_cmd = '0;
  logic [NM-1:0] drv_out;
  logic          aux_out, commit_pending;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_multi_out #(.CW(CW), .DEF_PERIOD(16)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .duty_cmd(duty_cmd), .drv_out(drv_out), .aux_out(aux_out),
    .commit_pending(commit_pending)
  );

  // reference model state
  int m_per, m_aper, s_per, s_aper, m_adj, s_adj, m_en, m_duty, m_cnt, m_acnt;
  int m_rise[7], m_fall[7], s_rise[7], s_fall[7];
  bit m_pend, m_blank;
  logic [NM-1:0] e_main;
  logic e_aux;

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic bit win(input int c, input int p, input int r, input int f);
    return (c >= mn(r, p)) && (c < mn(f, p));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_per = 16; m_aper = 16; s_per = 16; s_aper = 16;
      m_adj = 0; s_adj = 0; m_en = 0; m_duty = 0; m_cnt = 0; m_acnt = 0;
      m_pend = 0; m_blank = 0; e_main = '0; e_aux = 0;
      for (int i = 0; i < 7; i++) begin
        m_rise[i] = 0; m_fall[i] = 0; s_rise[i] = 0; s_fall[i] = 0;
      end
    end else begin
      bit roll, ld;
      for (int i = 0; i < NM; i++)
        e_main[i] = m_en[i] && !m_blank &&
                    win(m_cnt, m_per, m_rise[i], m_fall[i] + (m_adj[i] ? m_duty : 0));
      e_aux = m_en[6] && !m_blank && win(m_acnt, m_aper, m_rise[6], m_fall[6]);
      roll = (m_cnt + 1 >= m_per);
      ld   = roll && m_pend;
      if (ld) m_acnt = 0;
      else if (m_acnt + 1 >= m_aper) m_acnt = 0;
      else m_acnt++;
      m_cnt = roll ? 0 : m_cnt + 1;
      if (roll) begin m_duty = duty_cmd; m_blank = ld; end
      if (ld) begin
        m_per = s_per; m_aper = s_aper; m_adj = s_adj; m_pend = 0;
        for (int i = 0; i < 7; i++) begin m_rise[i] = s_rise[i]; m_fall[i] = s_fall[i]; end
      end
      if (wr_en) begin
        case (int'(wr_addr))
          0:  s_per = wr_data;
          13: s_adj = wr_data[5:0];
          14: s_aper = wr_data;
          15: s_rise[6] = wr_data;
          16: s_fall[6] = wr_data;
          17: m_en = wr_data[6:0];
          18: if (wr_data[0]) m_pend = 1;
          default: begin
            if (wr_addr >= 1 && wr_addr <= 6) s_rise[wr_addr-1] = wr_data;
            if (wr_addr >= 7 && wr_addr <= 12) s_fall[wr_addr-7] = wr_data;
          end
        endcase
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag);
    checks++;
    if (drv_out !== e_main || aux_out !== e_aux || commit_pending !== m_pend) begin
      errors++;
      $display("FAIL %s: drv=%b aux=%b pend=%b expected drv=%b aux=%b pend=%b",
               tag, drv_out, aux_out, commit_pending, e_main, e_aux, m_pend);
    end
  endtask

  task automatic chk_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d, input string tag);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = CW'(d);
    tick();
    wr_en = 1'b0;
    chk(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int k = 0; k < n; k++) begin tick(); chk(tag); end
  endtask

  task automatic commit_and_wait(input string tag);
    wr(18, 1, tag);
    for (int k = 0; k < 600 && m_pend; k++) begin tick(); chk(tag); end
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick(); chk("R1");
    chk_val("R1", int'(drv_out), 0);

    // held-back writes: nothing changes before commit (R4)
    wr(17, 8'h7F, "R7");
    wr(1, 2, "R4"); wr(7, 9, "R4"); wr(0, 10, "R4");
    run(40, "R4");
    chk_val("R4", int'(drv_out), 0);
    wr(18, 0, "R4");
    chk_val("R4", int'(commit_pending), 0);

    // commit pending then transfer (R11, R5)
    wr(18, 1, "R11");
    chk_val("R11", int'(commit_pending), 1);
    for (int k = 0; k < 40 && m_pend; k++) begin tick(); chk("R5"); end
    chk_val("R5", int'(commit_pending), 0);
    run(30, "R2");

    // blank length (R6)
    wr(1, 0, "R6"); wr(7, 200, "R6");
    commit_and_wait("R6");
    run(25, "R6");
    wr(0, 12, "R6");
    wr(18, 1, "R6");
    begin
      int streak = 0;
      for (int k = 0; k < 100; k++) begin
        tick(); chk("R6");
        if (drv_out[0] == 1'b0) streak++;
        else if (streak > 0) break;
      end
      chk_val("R6", streak, 12);
    end

    // independent edges per output (R3)
    for (int i = 0; i < NM; i++) begin
      wr(1 + i, i, "R3"); wr(7 + i, 2 * i + 3, "R3");
    end
    commit_and_wait("R3");
    run(40, "R3");

    // enable mask immediate (R7)
    wr(17, 8'h15, "R7"); run(20, "R7");
    wr(17, 8'h00, "R7"); run(15, "R7");
    chk_val("R7", int'(drv_out), 0);
    wr(17, 8'h7F, "R7");

    // duty shift on masked outputs (R8)
    wr(13, 6'h2A, "R8");
    commit_and_wait("R8");
    for (int k = 0; k < 80; k++) begin
      duty_cmd = CW'($urandom % 8);
      tick(); chk("R8");
    end
    duty_cmd = '0;

    // clamp and inverted edges (R9)
    wr(1, 200, "R9"); wr(7, 250, "R9");
    wr(2, 5, "R9");   wr(8, 3, "R9");
    wr(3, 4, "R9");   wr(9, 255, "R9");
    commit_and_wait("R9");
    run(40, "R9");

    // auxiliary channel own period (R10)
    wr(14, 5, "R10"); wr(15, 1, "R10"); wr(16, 3, "R10");
    commit_and_wait("R10");
    run(40, "R10");

    // commit landing on the rollover edge (R5)
    for (int k = 0; k < 40 && !(m_cnt + 1 >= m_per); k++) begin tick(); chk("R5"); end
    wr(18, 1, "R5");
    chk_val("R5", int'(commit_pending), 1);
    for (int k = 0; k < 40 && m_pend; k++) begin tick(); chk("R5"); end

    // random traffic (R2)
    for (int k = 0; k < 4000; k++) begin
      int sel = $urandom % 10;
      duty_cmd = CW'($urandom % 6);
      if (sel < 3) begin
        int a = $urandom % 19;
        int d = (a == 0 || a == 14) ? 3 + $urandom % 20 : $urandom % 32;
        if (a == 17) d = $urandom % 128;
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = CW'(d);
      end else begin
        wr_en = 1'b0;
      end
      tick(); chk("R2");
    end
    wr_en = 1'b0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule